// File: doc/BRIEF.md
# Prioritized Exception Request Selector

This block sits between the exception and interrupt request lines of a simple in-order core and that core's exception sequencing logic. On every cycle in which nothing is being presented, it qualifies all eighteen request lines. The qualification applies per-line masks, the debug-mode gate and the watchdog enable. The block then picks the single most urgent surviving line and registers it. The registered result carries three fields: a priority level code, the index of the winning line, and a bit that says whether the request is critical or noncritical.

The fifteen priority levels interleave the two classes: critical machine checks and debug events sit above and below the noncritical translation, program and alignment faults. Three levels are shared by two lines each, and inside a shared level the lower line index wins. The registered result is held unchanged until the core pulses an acknowledge. Later requests do not disturb it, even urgent ones. Once the acknowledge is taken the outputs clear, and selection resumes on the following cycle.

Top module: `exc_req_selector`

## Requirements
- R1: Lines are ranked by index, line 0 most urgent. The levels are: line 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→7, 7→8, 8 and 9→9, 10 and 11→10, 12→11, 13→12, 14 and 15→13, 16→14, 17→15. The winner is the pending qualified line with the lowest index.
- R2: `crit_o` is 1 for levels 1 to 6 and level 15, and 0 for levels 7 to 14.
- R3: With the default `MASKABLE` set (lines 0 to 5 and 17), a line whose `mask_i` bit is 1 is never selected. This covers the external critical input (line 4) and the watchdog (line 5).
- R4: On lines outside `MASKABLE` (6 to 16 by default), the `mask_i` bit has no effect.
- R5: The debug lines 1, 3 and 17 take part in selection only while `dbg_mode_i` is 1.
- R6: The watchdog line 5 is pending only when `req_i[5]` (time-out posted) and `wdog_en_i` are both 1.
- R7: The external critical line 4 is level-sensitive. If it is still high after an acknowledge, it is selected again on the next cycle.
- R8: Inside a shared level, the lower index wins. For example, lines 8 and 9 together give `src_o`=8 with level 9.
- R9: Requests present at a rising edge appear on the outputs just after that edge. The outputs do not change before it.
- R10: While `valid_o` is 1 and `ack_i` is 0, all outputs hold, even if a more urgent line rises.
- R11: An edge with `valid_o`=1 and `ack_i`=1 clears every output to zero. The next edge captures a fresh selection.
- R12: After reset, and whenever nothing qualified is pending, `valid_o`, `level_o`, `src_o` and `crit_o` are all zero.
- R13: `ack_i` is ignored while `valid_o` is 0. A qualified request arriving together with a stray acknowledge is still captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 18 | Request lines, index = rank |
| mask_i | input | 18 | Per-line mask, 1 blocks a maskable line |
| dbg_mode_i | input | 1 | Internal debug mode enable |
| wdog_en_i | input | 1 | Watchdog first time-out enable |
| ack_i | input | 1 | Acknowledge pulse from the core |
| valid_o | output | 1 | A request is being presented |
| level_o | output | 4 | Priority level code 1..15 |
| src_o | output | 5 | Winning line index |
| crit_o | output | 1 | 1 = critical class |

## Verification
Every result is due one rising edge after its stimulus. Inputs change on the falling edge, and the outputs are read 2 ns after the next rising edge. An acknowledge clears the outputs at the edge where it is sampled. A still-pending request shows up again one edge later, so the bench reads both of those edges separately. The hold checks raise a more urgent line while a result is presented and re-read the outputs over several later edges.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int NUM_LINES = 18;
    localparam int LVL_W     = 4;
    localparam int IDX_W     = $clog2(NUM_LINES);

    localparam logic [NUM_LINES-1:0] DEBUG_LINES = 18'h2000A;  // lines 1, 3, 17
    localparam int                   WDOG_LINE   = 5;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [IDX_W-1:0] src;
        logic             crit;
    } exc_sel_t;

    function automatic logic [LVL_W-1:0] level_of(input logic [IDX_W-1:0] idx);
        logic [LVL_W-1:0] l;
        case (idx)
            5'd0:           l = 4'd1;
            5'd1:           l = 4'd2;
            5'd2:           l = 4'd3;
            5'd3:           l = 4'd4;
            5'd4:           l = 4'd5;
            5'd5:           l = 4'd6;
            5'd6:           l = 4'd7;
            5'd7:           l = 4'd8;
            5'd8,  5'd9:    l = 4'd9;
            5'd10, 5'd11:   l = 4'd10;
            5'd12:          l = 4'd11;
            5'd13:          l = 4'd12;
            5'd14, 5'd15:   l = 4'd13;
            5'd16:          l = 4'd14;
            5'd17:          l = 4'd15;
            default:        l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic is_critical(input logic [LVL_W-1:0] lvl);
        return (lvl != 4'd0) && ((lvl <= 4'd6) || (lvl == 4'd15));
    endfunction

endpackage

// File: rtl/exc_sel_qualify.sv
module exc_sel_qualify
    import exc_sel_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] MASKABLE = 18'h2003F
) (
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 dbg_mode_i,
    input  logic                 wdog_en_i,
    output logic [NUM_LINES-1:0] elig_o
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic blocked;
        logic gate;
        assign blocked = MASKABLE[i] & mask_i[i];
        if (DEBUG_LINES[i]) begin : g_dbg
            assign gate = dbg_mode_i;
        end else if (i == WDOG_LINE) begin : g_wdog
            assign gate = wdog_en_i;
        end else begin : g_plain
            assign gate = 1'b1;
        end
        assign elig_o[i] = req_i[i] & ~blocked & gate;
    end

endmodule

// File: rtl/exc_sel_pick.sv
module exc_sel_pick
    import exc_sel_pkg::*;
(
    input  logic [NUM_LINES-1:0] elig_i,
    output exc_sel_t             sel_o
);

    logic [IDX_W-1:0] win;
    logic             any;

    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                win = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        sel_o = '0;
        if (any) begin
            sel_o.valid = 1'b1;
            sel_o.src   = win;
            sel_o.level = level_of(win);
            sel_o.crit  = is_critical(level_of(win));
        end
    end

endmodule

// File: rtl/exc_sel_hold.sv
module exc_sel_hold
    import exc_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  exc_sel_t sel_i,
    input  logic     ack_i,
    output exc_sel_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (q_o.valid) begin
            if (ack_i) q_o <= '0;
        end else begin
            q_o <= sel_i;
        end
    end

    // R10: presented result is frozen until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (q_o.valid && !ack_i) |=> $stable(q_o));

    // R11: acknowledge clears the presented result
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (q_o.valid && ack_i) |=> (q_o == '0));

    // R13: a stray acknowledge does not block capture
    a_r13_capture: assert property (@(posedge clk) disable iff (rst)
        (!q_o.valid && sel_i.valid) |=> (q_o.valid && q_o.src == $past(sel_i.src)));

    // R12: idle outputs are all zero
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !q_o.valid |-> (q_o.level == '0 && q_o.src == '0 && !q_o.crit));

endmodule

// File: rtl/exc_req_selector.sv
module exc_req_selector
    import exc_sel_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] MASKABLE = 18'h2003F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 dbg_mode_i,
    input  logic                 wdog_en_i,
    input  logic                 ack_i,
    output logic                 valid_o,
    output logic [LVL_W-1:0]     level_o,
    output logic [IDX_W-1:0]     src_o,
    output logic                 crit_o
);

    logic [NUM_LINES-1:0] elig;
    exc_sel_t             sel;
    exc_sel_t             held;

    exc_sel_qualify #(.MASKABLE(MASKABLE)) u_qual (
        .req_i      (req_i),
        .mask_i     (mask_i),
        .dbg_mode_i (dbg_mode_i),
        .wdog_en_i  (wdog_en_i),
        .elig_o     (elig)
    );

    exc_sel_pick u_pick (
        .elig_i (elig),
        .sel_o  (sel)
    );

    exc_sel_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .sel_i (sel),
        .ack_i (ack_i),
        .q_o   (held)
    );

    assign valid_o = held.valid;
    assign level_o = held.level;
    assign src_o   = held.src;
    assign crit_o  = held.crit;

    // R3: a masked external critical line never becomes the new winner
    a_r3_masked_ext: assert property (@(posedge clk) disable iff (rst)
        (MASKABLE[4] && valid_o && !$past(valid_o) && src_o == 5'd4) |-> !$past(mask_i[4]));

    // R5: debug lines win only with debug mode on
    a_r5_dbg_gate: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(valid_o) && DEBUG_LINES[src_o]) |-> $past(dbg_mode_i));

    // R6: watchdog wins only with its enable
    a_r6_wdog_gate: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(valid_o) && src_o == 5'd5) |-> ($past(wdog_en_i) && $past(req_i[5])));

    // R2: class bit agrees with level code
    a_r2_class: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (crit_o == ((level_o <= 4'd6) || (level_o == 4'd15))));

endmodule

// File: tb/tb_exc_req_selector.sv
module tb_exc_req_selector;

    logic        clk = 1'b0;
    logic        rst;
    logic [17:0] req, mask;
    logic        dbg, wen, ack;
    logic        valid_o, crit_o;
    logic [3:0]  level_o;
    logic [4:0]  src_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    exc_req_selector dut (
        .clk(clk), .rst(rst), .req_i(req), .mask_i(mask),
        .dbg_mode_i(dbg), .wdog_en_i(wen), .ack_i(ack),
        .valid_o(valid_o), .level_o(level_o), .src_o(src_o), .crit_o(crit_o)
    );

    typedef struct packed {
        logic [17:0] rq;
        logic [17:0] mk;
        logic        db;
        logic        we;
        logic        ev;
        logic [3:0]  lv;
        logic [4:0]  sr;
        logic        cr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{18'h3FFFF, 18'h00000, 1'b1, 1'b1, 1'b1, 4'd1,  5'd0,  1'b1}, // R1
        '{18'h3FFFE, 18'h00000, 1'b1, 1'b1, 1'b1, 4'd2,  5'd1,  1'b1}, // R1 R5
        '{18'h3FFFE, 18'h00000, 1'b0, 1'b1, 1'b1, 4'd3,  5'd2,  1'b1}, // R5
        '{18'h00048, 18'h00000, 1'b1, 1'b0, 1'b1, 4'd4,  5'd3,  1'b1}, // R1
        '{18'h00050, 18'h00010, 1'b0, 1'b0, 1'b1, 4'd7,  5'd6,  1'b0}, // R3 R2
        '{18'h000A0, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd8,  5'd7,  1'b0}, // R6
        '{18'h000A0, 18'h00000, 1'b0, 1'b1, 1'b1, 4'd6,  5'd5,  1'b1}, // R6
        '{18'h00300, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd9,  5'd8,  1'b0}, // R8
        '{18'h00200, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd9,  5'd9,  1'b0}, // R8
        '{18'h00C00, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd10, 5'd10, 1'b0}, // R8
        '{18'h01800, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd10, 5'd11, 1'b0}, // R1
        '{18'h1C000, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd13, 5'd14, 1'b0}, // R8
        '{18'h30000, 18'h00000, 1'b1, 1'b0, 1'b1, 4'd14, 5'd16, 1'b0}, // R1 R2
        '{18'h20000, 18'h00000, 1'b1, 1'b0, 1'b1, 4'd15, 5'd17, 1'b1}, // R2 R5
        '{18'h20000, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd0,  5'd0,  1'b0}, // R5 R12
        '{18'h02040, 18'h3FFFF, 1'b0, 1'b1, 1'b1, 4'd7,  5'd6,  1'b0}, // R4
        '{18'h00020, 18'h00020, 1'b0, 1'b1, 1'b0, 4'd0,  5'd0,  1'b0}, // R3
        '{18'h02001, 18'h00001, 1'b0, 1'b0, 1'b1, 4'd12, 5'd13, 1'b0}  // R3
    };

    task automatic chk(input string tag, input logic ev, input logic [3:0] lv,
                       input logic [4:0] sr, input logic cr);
        checks++;
        if ({valid_o, level_o, src_o, crit_o} !== {ev, lv, sr, cr}) begin
            errors++;
            $display("FAIL %s: got valid=%0b level=%0d src=%0d crit=%0b, expected valid=%0b level=%0d src=%0d crit=%0b",
                     tag, valid_o, level_o, src_o, crit_o, ev, lv, sr, cr);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [17:0] r, input logic [17:0] m, input logic d,
                         input logic w, input logic a);
        @(negedge clk);
        req = r; mask = m; dbg = d; wen = w; ack = a;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req = '0; mask = '0; dbg = 1'b0; wen = 1'b0; ack = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        chk("R12 reset state", 1'b0, 4'd0, 5'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // vector table: apply, check capture, acknowledge, check clear (R9, R11)
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].rq, VECS[k].mk, VECS[k].db, VECS[k].we, 1'b0);
            #1;
            chk("R9 no change before edge", 1'b0, 4'd0, 5'd0, 1'b0);
            edge_sample();
            chk($sformatf("R1 vector %0d", k), VECS[k].ev, VECS[k].lv, VECS[k].sr, VECS[k].cr);
            drive('0, '0, 1'b0, 1'b0, 1'b1);
            edge_sample();
            chk("R11 clear after ack", 1'b0, 4'd0, 5'd0, 1'b0);
            drive('0, '0, 1'b0, 1'b0, 1'b0);
        end

        // R10: hold while a more urgent line rises
        drive(18'h01000, '0, 1'b1, 1'b1, 1'b0);
        edge_sample();
        chk("R10 capture", 1'b1, 4'd11, 5'd12, 1'b0);
        drive(18'h01001, '0, 1'b1, 1'b1, 1'b0);
        for (int c = 0; c < 3; c++) begin
            edge_sample();
            chk("R10 hold", 1'b1, 4'd11, 5'd12, 1'b0);
        end
        drive(18'h01001, '0, 1'b1, 1'b1, 1'b1);
        edge_sample();
        chk("R11 ack clears", 1'b0, 4'd0, 5'd0, 1'b0);
        drive(18'h01001, '0, 1'b1, 1'b1, 1'b0);
        edge_sample();
        chk("R11 reselect next edge", 1'b1, 4'd1, 5'd0, 1'b1);
        drive('0, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        drive('0, '0, 1'b0, 1'b0, 1'b0);

        // R7: level-sensitive external critical input
        drive(18'h00010, '0, 1'b0, 1'b0, 1'b0);
        edge_sample();
        chk("R7 ext capture", 1'b1, 4'd5, 5'd4, 1'b1);
        drive(18'h00010, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        chk("R7 ack clears", 1'b0, 4'd0, 5'd0, 1'b0);
        drive(18'h00010, '0, 1'b0, 1'b0, 1'b0);
        edge_sample();
        chk("R7 still pending reselected", 1'b1, 4'd5, 5'd4, 1'b1);
        drive('0, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        drive('0, '0, 1'b0, 1'b0, 1'b0);

        // R13: acknowledge while idle is ignored
        drive('0, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        chk("R13 idle ack", 1'b0, 4'd0, 5'd0, 1'b0);
        drive(18'h00400, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        chk("R13 capture despite ack", 1'b1, 4'd10, 5'd10, 1'b0);
        drive('0, '0, 1'b0, 1'b0, 1'b0);
        edge_sample();
        chk("R13 held after capture", 1'b1, 4'd10, 5'd10, 1'b0);
        drive('0, '0, 1'b0, 1'b0, 1'b1);
        edge_sample();
        drive('0, '0, 1'b0, 1'b0, 1'b0);

        // R12: nothing pending stays idle
        edge_sample();
        chk("R12 idle", 1'b0, 4'd0, 5'd0, 1'b0);

        finish_run();
    end

endmodule